// File: doc/BRIEF.md
# Dual Accumulator with Saturation Flags

This block holds two 40-bit signed accumulators that share a single 40-bit adder/subtracter. On each valid operation one accumulator is picked as both the source and the destination. The incoming 40-bit operand is added to it or subtracted from it. An operation can instead force the accumulator side of the adder to zero, which loads the operand or its negation. The result is written back on the next clock edge.

Each accumulator keeps a guard-bit overflow flag and a sticky saturation flag. Each accumulator can be set to saturate. One shared mode bit decides whether saturation clamps at the 32-bit or the 40-bit signed boundary. The flags are combined into summary outputs. Two trap request outputs present the flags through enable masks: one for guard overflow, and one for catastrophic overflow on an accumulator that is not saturating.

Top module: `dacc_unit`

## Requirements
- R1: After reset both accumulators are 0 and every flag, summary and trap output is 0.
- R2: With `op_i`=0 (add) the selected accumulator becomes acc + operand. With `op_i`=1 (subtract) it becomes acc - operand. Both results wrap modulo 2^40 when saturation is off.
- R3: With `op_i`=2 (load) the selected accumulator becomes the operand. With `op_i`=3 (negate-load) it becomes 0 - operand.
- R4: `acc_sel_i`=0 selects accumulator A and 1 selects B. The unselected accumulator and its flags do not change. While `op_valid_i` is low nothing but sticky-flag clears changes.
- R5: On each valid operation the overflow flag of the selected accumulator (`ovf_o` bit 0 for A, bit 1 for B) is recomputed. It is 1 exactly when bits 39..32 of the unclamped 40-bit result are not all equal.
- R6: With saturation enabled and `sat_wide_i`=1, a true result above 2^39-1 is written as 0x7FFFFFFFFF and one below -2^39 is written as 0x8000000000. Each case sets the saturation flag.
- R7: With saturation enabled and `sat_wide_i`=0, a true result outside [-2^31, 2^31-1] is written as 0x007FFFFFFF (positive) or 0xFF80000000 (negative). Each case sets the saturation flag.
- R8: With saturation disabled for the selected accumulator, the result wraps. Its saturation flag is set when the true result leaves the 40-bit signed range.
- R9: A saturation flag stays set until its `sat_clr_i` bit is high. A clear in the same cycle as a new saturation event on that accumulator is overridden by the event.
- R10: `ovf_any_o` is the OR of both overflow flags. `sat_any_o` is the OR of both saturation flags.
- R11: `ovf_trap_o` is high when any overflow flag is set with its `ovf_trap_en_i` bit. `cat_trap_o` is high when `cat_trap_en_i` is set and a saturation flag is set on an accumulator whose `sat_en_i` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Perform an operation this cycle |
| op_i | input | 2 | 0 add, 1 subtract, 2 load, 3 negate-load |
| acc_sel_i | input | 1 | 0 selects A, 1 selects B |
| operand_i | input | 40 | Signed operand |
| sat_en_i | input | 2 | Saturation enable, bit 0 A, bit 1 B |
| sat_wide_i | input | 1 | 1 saturate at 40 bits, 0 at 32 bits |
| sat_clr_i | input | 2 | Clear saturation flag, bit 0 A, bit 1 B |
| ovf_trap_en_i | input | 2 | Guard overflow trap enables |
| cat_trap_en_i | input | 1 | Catastrophic overflow trap enable |
| acc_a_o | output | 40 | Accumulator A |
| acc_b_o | output | 40 | Accumulator B |
| ovf_o | output | 2 | Guard overflow flags |
| sat_o | output | 2 | Sticky saturation flags |
| ovf_any_o | output | 1 | OR of overflow flags |
| sat_any_o | output | 1 | OR of saturation flags |
| ovf_trap_o | output | 1 | Gated guard overflow trap request |
| cat_trap_o | output | 1 | Gated catastrophic overflow trap request |

## Verification
The hardest case to reach is a 40-bit catastrophic overflow. It needs an accumulator that already sits near ±2^39, and then an operand that pushes it past the limit in the same direction. Uniform random operands almost never do both. The directed part of the bench loads extreme values such as 0x7FFFFFFFFF and 0x8000000000, then adds or subtracts small values. The random part draws operands from a mix of small, 32-bit-edge and full-range magnitudes, and it selects load often. That way both accumulators keep landing near the boundaries. A further corner is a clear that arrives in the same cycle as a fresh saturation event. It is driven explicitly and also comes up again in the random phase.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_LOAD = 2'd2,
    OP_NEG  = 2'd3
  } dacc_op_e;
endpackage

// File: rtl/dacc_addsub.sv
module dacc_addsub import dacc_pkg::*; #(
  parameter int ACC_W = 40
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [ACC_W-1:0] operand_i,
  input  dacc_op_e         op_i,
  output logic [ACC_W:0]   sum_ext_o
);
  logic             zero_a, invert_b;
  logic [ACC_W-1:0] a_side, b_side;

  assign zero_a   = (op_i == OP_LOAD) || (op_i == OP_NEG);
  assign invert_b = (op_i == OP_SUB)  || (op_i == OP_NEG);
  assign a_side   = zero_a ? '0 : acc_i;
  assign b_side   = invert_b ? ~operand_i : operand_i;

  // one extra sign bit keeps the true sign of the sum
  assign sum_ext_o = {a_side[ACC_W-1], a_side} + {b_side[ACC_W-1], b_side}
                   + {{ACC_W{1'b0}}, invert_b};
endmodule

// File: rtl/dacc_sat.sv
module dacc_sat #(
  parameter int ACC_W    = 40,
  parameter int NARROW_W = 32
) (
  input  logic [ACC_W:0]   sum_ext_i,
  input  logic             sat_en_i,
  input  logic             wide_i,
  output logic [ACC_W-1:0] result_o,
  output logic             guard_ovf_o,
  output logic             sat_evt_o
);
  localparam int GUARD_W = ACC_W - NARROW_W;
  localparam logic [ACC_W-1:0] MAX_W = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MIN_W = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] MAX_N = {{(GUARD_W+1){1'b0}}, {(NARROW_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MIN_N = {{(GUARD_W+1){1'b1}}, {(NARROW_W-1){1'b0}}};

  logic [ACC_W-1:0] raw;
  logic             true_neg, cat_ovf, out_narrow;
  logic [GUARD_W-1:0] guard;
  logic [GUARD_W+1:0] top_n;

  assign raw        = sum_ext_i[ACC_W-1:0];
  assign true_neg   = sum_ext_i[ACC_W];
  assign cat_ovf    = sum_ext_i[ACC_W] ^ sum_ext_i[ACC_W-1];
  assign guard      = raw[ACC_W-1:NARROW_W];
  assign guard_ovf_o = !((&guard) || !(|guard));
  assign top_n      = sum_ext_i[ACC_W:NARROW_W-1];
  assign out_narrow = !((&top_n) || !(|top_n));

  always_comb begin
    result_o  = raw;
    sat_evt_o = cat_ovf;
    if (sat_en_i) begin
      if (wide_i) begin
        if (cat_ovf) result_o = true_neg ? MIN_W : MAX_W;
      end else begin
        sat_evt_o = out_narrow;
        if (out_narrow) result_o = true_neg ? MIN_N : MAX_N;
      end
    end
  end

  always_comb begin
    if (sat_en_i && wide_i && cat_ovf)
      a_clamp_w_r6: assert (result_o == MAX_W || result_o == MIN_W);
    if (sat_en_i && !wide_i)
      a_narrow_range_r7: assert ((&result_o[ACC_W-1:NARROW_W-1]) ||
                                 !(|result_o[ACC_W-1:NARROW_W-1]));
  end
endmodule

// File: rtl/dacc_reg.sv
module dacc_reg #(
  parameter int ACC_W = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [ACC_W-1:0] result_i,
  input  logic             guard_ovf_i,
  input  logic             sat_evt_i,
  input  logic             clr_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             ovf_o,
  output logic             sat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o <= '0;
      ovf_o <= 1'b0;
      sat_o <= 1'b0;
    end else begin
      if (we_i) begin
        acc_o <= result_i;
        ovf_o <= guard_ovf_i;
      end
      // a new event beats a clear in the same cycle
      if (we_i && sat_evt_i) sat_o <= 1'b1;
      else if (clr_i)        sat_o <= 1'b0;
    end
  end

  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_o && !clr_i |=> sat_o);
  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !(we_i && sat_evt_i) |=> !sat_o);
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(acc_o) && $stable(ovf_o));
endmodule

// File: rtl/dacc_unit.sv
module dacc_unit import dacc_pkg::*; #(
  parameter int ACC_W    = 40,
  parameter int NARROW_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_valid_i,
  input  logic [1:0]       op_i,
  input  logic             acc_sel_i,
  input  logic [ACC_W-1:0] operand_i,
  input  logic [1:0]       sat_en_i,
  input  logic             sat_wide_i,
  input  logic [1:0]       sat_clr_i,
  input  logic [1:0]       ovf_trap_en_i,
  input  logic             cat_trap_en_i,
  output logic [ACC_W-1:0] acc_a_o,
  output logic [ACC_W-1:0] acc_b_o,
  output logic [1:0]       ovf_o,
  output logic [1:0]       sat_o,
  output logic             ovf_any_o,
  output logic             sat_any_o,
  output logic             ovf_trap_o,
  output logic             cat_trap_o
);
  localparam int N_ACC = 2;

  logic [ACC_W-1:0] acc_q [N_ACC];
  logic [ACC_W-1:0] src_acc, result;
  logic [ACC_W:0]   sum_ext;
  logic             guard_ovf, sat_evt, sel_sat_en;

  assign src_acc    = acc_q[acc_sel_i];
  assign sel_sat_en = sat_en_i[acc_sel_i];

  dacc_addsub #(.ACC_W(ACC_W)) u_addsub (
    .acc_i     (src_acc),
    .operand_i (operand_i),
    .op_i      (dacc_op_e'(op_i)),
    .sum_ext_o (sum_ext)
  );

  dacc_sat #(.ACC_W(ACC_W), .NARROW_W(NARROW_W)) u_sat (
    .sum_ext_i   (sum_ext),
    .sat_en_i    (sel_sat_en),
    .wide_i      (sat_wide_i),
    .result_o    (result),
    .guard_ovf_o (guard_ovf),
    .sat_evt_o   (sat_evt)
  );

  for (genvar g = 0; g < N_ACC; g++) begin : g_acc
    dacc_reg #(.ACC_W(ACC_W)) u_reg (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .we_i        (op_valid_i && (acc_sel_i == 1'(g))),
      .result_i    (result),
      .guard_ovf_i (guard_ovf),
      .sat_evt_i   (sat_evt),
      .clr_i       (sat_clr_i[g]),
      .acc_o       (acc_q[g]),
      .ovf_o       (ovf_o[g]),
      .sat_o       (sat_o[g])
    );
  end

  assign acc_a_o    = acc_q[0];
  assign acc_b_o    = acc_q[1];
  assign ovf_any_o  = |ovf_o;
  assign sat_any_o  = |sat_o;
  assign ovf_trap_o = |(ovf_o & ovf_trap_en_i);
  assign cat_trap_o = cat_trap_en_i && |(sat_o & ~sat_en_i);

  p_cat_trap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cat_trap_o |-> sat_any_o && (sat_en_i != 2'b11));
  p_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> $stable(acc_a_o) && $stable(acc_b_o) && $stable(ovf_o));
endmodule

// File: tb/dacc_unit_test.sv
`timescale 1ns/1ps
module dacc_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op = '0;
  logic        sel = 1'b0;
  logic [39:0] operand = '0;
  logic [1:0]  sat_en = '0;
  logic        wide = 1'b0;
  logic [1:0]  sat_clr = '0;
  logic [1:0]  ovf_ten = '0;
  logic        cat_ten = 1'b0;
  logic [39:0] acc_a, acc_b;
  logic [1:0]  ovf, sat;
  logic        ovf_any, sat_any, ovf_trap, cat_trap;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [39:0] m_acc [2];
  logic [1:0]  m_ovf, m_sat;

  always #2.5 clk = ~clk;

  dacc_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_i(op),
    .acc_sel_i(sel), .operand_i(operand), .sat_en_i(sat_en),
    .sat_wide_i(wide), .sat_clr_i(sat_clr), .ovf_trap_en_i(ovf_ten),
    .cat_trap_en_i(cat_ten), .acc_a_o(acc_a), .acc_b_o(acc_b),
    .ovf_o(ovf), .sat_o(sat), .ovf_any_o(ovf_any), .sat_any_o(sat_any),
    .ovf_trap_o(ovf_trap), .cat_trap_o(cat_trap)
  );

  task automatic check(string req, logic [39:0] got, logic [39:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // reference model from requirements R2..R9
  task automatic model_step();
    longint a, b, t, pmax, nmin;
    logic [39:0] res;
    bit ev, oflow;
    a = longint'($signed(m_acc[sel]));
    b = longint'($signed(operand));
    case (op)
      2'd0: t = a + b;
      2'd1: t = a - b;
      2'd2: t = b;
      default: t = -b;
    endcase
    res = t[39:0];
    oflow = !(res[39:32] == 8'hFF || res[39:32] == 8'h00);
    ev = (t > 64'sd549755813887) || (t < -64'sd549755813888);
    if (sat_en[sel]) begin
      pmax = wide ? 64'sd549755813887 : 64'sd2147483647;
      nmin = wide ? -64'sd549755813888 : -64'sd2147483648;
      ev = (t > pmax) || (t < nmin);
      if (t > pmax) res = pmax[39:0];
      if (t < nmin) res = nmin[39:0];
    end
    for (int i = 0; i < 2; i++) begin
      if (op_valid && sel == 1'(i)) begin
        m_acc[i] = res;
        m_ovf[i] = oflow;
        if (ev) m_sat[i] = 1'b1;
        else if (sat_clr[i]) m_sat[i] = 1'b0;
      end else if (sat_clr[i]) m_sat[i] = 1'b0;
    end
  endtask

  task automatic check_all(string req);
    check({req, " accA"}, acc_a, m_acc[0]);
    check({req, " accB"}, acc_b, m_acc[1]);
    check({req, " ovf R5"}, 40'(ovf), 40'(m_ovf));
    check({req, " sat R9"}, 40'(sat), 40'(m_sat));
    check("R10 any", {38'd0, ovf_any, sat_any}, {38'd0, |m_ovf, |m_sat});
    check("R11 traps", {38'd0, ovf_trap, cat_trap},
          {38'd0, |(m_ovf & ovf_ten), cat_ten && |(m_sat & ~sat_en)});
  endtask

  task automatic step(string req, bit v, logic [1:0] o, bit s, logic [39:0] d,
                      logic [1:0] se, bit w, logic [1:0] clr);
    op_valid = v; op = o; sel = s; operand = d;
    sat_en = se; wide = w; sat_clr = clr;
    model_step();
    @(posedge clk);
    @(negedge clk);
    check_all(req);
  endtask

  function automatic logic [39:0] rnd_operand();
    int k;
    k = $urandom_range(0, 5);
    case (k)
      0: return 40'($urandom_range(0, 255));
      1: return -40'($urandom_range(0, 255));
      2: return 40'h007FFFFF00 + 40'($urandom_range(0, 511));
      3: return 40'hFF80000000 - 40'($urandom_range(0, 511)) + 40'd256;
      4: return 40'h7FFFFFFF00 + 40'($urandom_range(0, 255));
      default: return {$urandom(), $urandom()} & 40'hFF_FFFF_FFFF;
    endcase
  endfunction

  initial begin
    #(5ns * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1729));
    m_acc[0] = '0; m_acc[1] = '0; m_ovf = '0; m_sat = '0;
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    ovf_ten = 2'b11; cat_ten = 1'b1;
    // R2 add / subtract, R3 load / negate
    step("R2 add",  1, 2'd0, 0, 40'd100, 2'b00, 1, 2'b00);
    step("R2 sub",  1, 2'd1, 0, 40'd250, 2'b00, 1, 2'b00);
    step("R3 load", 1, 2'd2, 1, 40'h0012345678, 2'b00, 1, 2'b00);
    step("R3 neg",  1, 2'd3, 1, 40'd5, 2'b00, 1, 2'b00);
    // R4 idle holds state
    step("R4 idle", 0, 2'd0, 0, 40'h7FFFFFFFFF, 2'b00, 1, 2'b00);
    // R5 guard overflow and recompute
    step("R5 guard set",   1, 2'd2, 0, 40'h0100000000, 2'b00, 1, 2'b00);
    step("R5 guard clear", 1, 2'd2, 0, 40'h0000000001, 2'b00, 1, 2'b00);
    // R8 wrap without saturation sets flag; cat trap
    step("R8 load max", 1, 2'd2, 0, 40'h7FFFFFFFFF, 2'b00, 1, 2'b00);
    step("R8 wrap",     1, 2'd0, 0, 40'd1, 2'b00, 1, 2'b00);
    step("R9 held",     1, 2'd2, 0, 40'd0, 2'b00, 1, 2'b00);
    step("R9 clear",    0, 2'd0, 0, 40'd0, 2'b00, 1, 2'b01);
    // R6 40-bit clamp both directions
    step("R6 load",  1, 2'd2, 1, 40'h7FFFFFFFF0, 2'b10, 1, 2'b00);
    step("R6 pos",   1, 2'd0, 1, 40'h0000000100, 2'b10, 1, 2'b00);
    step("R6 neg",   1, 2'd3, 1, 40'h0000000000, 2'b10, 1, 2'b10);
    step("R6 negld", 1, 2'd2, 1, 40'h8000000000, 2'b10, 1, 2'b10);
    step("R6 min",   1, 2'd1, 1, 40'd7, 2'b10, 1, 2'b00);
    step("R3 neg of min", 1, 2'd3, 1, 40'h8000000000, 2'b10, 1, 2'b10);
    // R7 32-bit clamp both directions
    step("R7 pos", 1, 2'd2, 0, 40'h0080000000, 2'b01, 0, 2'b01);
    step("R7 neg", 1, 2'd2, 0, 40'hFF7FFFFFFF, 2'b01, 0, 2'b01);
    step("R7 in range", 1, 2'd0, 0, 40'd1, 2'b01, 0, 2'b01);
    // R9 clear loses to a simultaneous event
    step("R9 clr vs evt", 1, 2'd2, 0, 40'h0100000000, 2'b01, 0, 2'b01);
    step("R11 mask", 1, 2'd2, 1, 40'd0, 2'b00, 0, 2'b00);
    ovf_ten = 2'b00; cat_ten = 1'b0;
    step("R11 off", 0, 2'd0, 0, 40'd0, 2'b00, 0, 2'b00);
    // random phase
    for (int n = 0; n < 3000; n++) begin
      ovf_ten = 2'($urandom());
      cat_ten = 1'($urandom());
      step("R2-mix rnd", ($urandom_range(0, 7) != 0), 2'($urandom()),
           1'($urandom()), rnd_operand(), 2'($urandom()), 1'($urandom()),
           ($urandom_range(0, 5) == 0) ? 2'($urandom()) : 2'b00);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule